// File: doc/BRIEF.md
# Real-Time Clock with Published Time Registers and Coherent Seconds Capture

This block is a memory-mapped real-time clock. A single-cycle `slow_tick` enable, derived from a 32 kHz reference, drives a prescaler, a milliseconds counter and a 32-bit seconds counter. The bus does not see these live counters directly. Once every `COPY_PERIOD` slow ticks the block starts a short publish window. During that window a busy flag is raised, and at the end of the window the live values are copied into the registers that the bus reads.

Software reads the milliseconds register first. That read loads the published seconds value into a shadow register, and a later read of the shadow register returns seconds that belong to the same instant. Two seconds-compare alarms each set a sticky pending bit, which software clears by writing 1 to it. An enable mask selects which pending bits drive the level interrupt output.

Top module: `rtc_shadow_timer`

## Requirements
- R1: While `rst_n` is low, every counter, alarm value, mask bit, pending bit and the shadow register goes to zero, and `irq` is low. After reset, every readable register reads zero.
- R2: The milliseconds count advances once every `TICKS_PER_MS` slow ticks. When it advances from `MS_PER_SEC-1` it returns to 0 and the seconds count increments on that same tick. Seconds wrap from 0xFFFFFFFF to 0.
- R3: The seconds register (0x08) and the milliseconds register (0x10) change only through a publish. A publish starts on every `COPY_PERIOD`-th slow tick. Bit 0 of the busy register (0x04) reads 1 for `BUSY_CYCLES` clocks beginning the clock after that tick. On the last of those clocks the live counts are copied, and bit 0 then reads 0.
- R4: A bus read of the milliseconds register (0x10) loads the published seconds value into the shadow register (0x0C). No other access changes the shadow register.
- R5: A write to the seconds register (0x08) sets the live seconds count. The write is accepted even while busy reads 1. Reads of 0x08 return the old value until the next publish completes, and after that publish they return the new count.
- R6: Alarm A (0x14) drives pending bit 0 and alarm B (0x18) drives pending bit 1. A pending bit sets on the tick where the seconds count increments to a value equal to its nonzero alarm value. It sets regardless of the mask.
- R7: An alarm holding 0 never sets its pending bit, including when the seconds count wraps to 0.
- R8: The pending register (0x2C) clears only the bits written as 1 and leaves the other bits unchanged. Bits 4..2 always read 0.
- R9: The enable mask (0x28, bits 4..0, same bit layout as the pending register) is read/write. `irq` is high exactly while some pending bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slow_tick | input | 1 | Single-cycle enable, one per 32 kHz period |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with `TICKS_PER_MS=2`, `MS_PER_SEC=5` and `BUSY_CYCLES=3`. With these values one second takes ten slow ticks. A publish every eight ticks then lands on a different millisecond phase each time, so the published value is not stuck at one phase. Alarm hits and the 32-bit seconds wrap also occur within a few dozen ticks. A three-clock busy window leaves a gap in which the bench can confirm that busy reads 1 and then place a seconds write on the same clock as the copy, which shows that the write appears only at the following publish.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  // Register byte offsets decoded by the bus side
  localparam int unsigned REG_BUSY   = 32'h04;
  localparam int unsigned REG_SECS   = 32'h08;
  localparam int unsigned REG_SHADOW = 32'h0C;
  localparam int unsigned REG_MSEC   = 32'h10;
  localparam int unsigned REG_ALM0   = 32'h14;  // alarm B at REG_ALM0 + 4
  localparam int unsigned REG_MASK   = 32'h28;
  localparam int unsigned REG_STAT   = 32'h2C;

  // Pending and mask layout: bit 0 alarm A, bit 1 alarm B, bits 4..2 unused
  localparam int unsigned STAT_W  = 5;
  localparam int unsigned N_ALARM = 2;

  typedef logic [31:0] word_t;
endpackage

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
module rtc_time_core #(
  parameter int unsigned TICKS_PER_MS = 32,
  parameter int unsigned MS_PER_SEC   = 1000,
  parameter int unsigned MS_W         = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic            sec_load,
  input  logic [31:0]     sec_wdata,
  output logic [MS_W-1:0] ms_q,
  output logic [31:0]     sec_q,
  output logic            sec_step,
  output logic [31:0]     sec_next
);
  logic            ms_step;
  logic            ms_wrap;
  logic [MS_W-1:0] ms_d;
  logic [31:0]     sec_d;

  // Prescaler only when more than one slow tick makes a millisecond
  generate
    if (TICKS_PER_MS > 1) begin : g_pre
      localparam int unsigned PRE_W = $clog2(TICKS_PER_MS);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_wrap;
      assign pre_wrap = (pre_q == PRE_W'(TICKS_PER_MS - 1));
      always_comb begin
        pre_d = pre_q;
        if (slow_tick) pre_d = pre_wrap ? '0 : pre_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
      assign ms_step = slow_tick & pre_wrap;
    end else begin : g_nopre
      assign ms_step = slow_tick;
    end
  endgenerate

  assign ms_wrap  = (ms_q == MS_W'(MS_PER_SEC - 1));
  assign sec_step = ms_step & ms_wrap;
  assign sec_next = sec_q + 32'd1;

  always_comb begin
    ms_d = ms_q;
    if (ms_step) ms_d = ms_wrap ? '0 : ms_q + 1'b1;
    sec_d = sec_q;
    if (sec_load)      sec_d = sec_wdata;
    else if (sec_step) sec_d = sec_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else begin
      ms_q  <= ms_d;
      sec_q <= sec_d;
    end
  end
endmodule

// File: rtl/rtc_publish.sv
`timescale 1ns/1ps
module rtc_publish #(
  parameter int unsigned COPY_PERIOD = 8,
  parameter int unsigned BUSY_CYCLES = 2,
  parameter int unsigned MS_W        = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slow_tick,
  input  logic [31:0]     live_sec,
  input  logic [MS_W-1:0] live_ms,
  output logic [31:0]     pub_sec,
  output logic [MS_W-1:0] pub_ms,
  output logic            busy
);
  localparam int unsigned CP_W = (COPY_PERIOD > 1) ? $clog2(COPY_PERIOD) : 1;
  localparam int unsigned BC_W = $clog2(BUSY_CYCLES + 1);

  logic [CP_W-1:0] cp_q, cp_d;
  logic [BC_W-1:0] bc_q, bc_d;
  logic            cp_last, start, capture;
  logic [31:0]     psec_d;
  logic [MS_W-1:0] pms_d;

  assign cp_last = (cp_q == CP_W'(COPY_PERIOD - 1));
  assign start   = slow_tick & cp_last;
  assign capture = (bc_q == BC_W'(1));
  assign busy    = (bc_q != '0);

  always_comb begin
    cp_d = cp_q;
    if (slow_tick) cp_d = cp_last ? '0 : cp_q + 1'b1;
    bc_d = bc_q;
    if (start)      bc_d = BC_W'(BUSY_CYCLES);
    else if (busy)  bc_d = bc_q - 1'b1;
    psec_d = pub_sec;
    pms_d  = pub_ms;
    if (capture) begin
      psec_d = live_sec;
      pms_d  = live_ms;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q    <= '0;
      bc_q    <= '0;
      pub_sec <= '0;
      pub_ms  <= '0;
    end else begin
      cp_q    <= cp_d;
      bc_q    <= bc_d;
      pub_sec <= psec_d;
      pub_ms  <= pms_d;
    end
  end
endmodule

// File: rtl/rtc_alarm_irq.sv
`timescale 1ns/1ps
module rtc_alarm_irq #(
  parameter int unsigned N_ALARM = 2,
  parameter int unsigned STAT_W  = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           sec_step,
  input  logic [31:0]                    sec_next,
  input  logic [N_ALARM-1:0][31:0]       alarm_val,
  input  logic                           clr_we,
  input  logic                           mask_we,
  input  logic [STAT_W-1:0]              wdata_lo,
  output logic [STAT_W-1:0]              status_q,
  output logic [STAT_W-1:0]              mask_q,
  output logic [N_ALARM-1:0]             hit,
  output logic                           irq
);
  logic [STAT_W-1:0] set_vec, status_d, mask_d;

  generate
    for (genvar i = 0; i < N_ALARM; i++) begin : g_cmp
      assign hit[i] = sec_step && (alarm_val[i] != '0) && (sec_next == alarm_val[i]);
    end
  endgenerate

  always_comb begin
    set_vec              = '0;
    set_vec[N_ALARM-1:0] = hit;
    status_d = (status_q & ~(clr_we ? wdata_lo : '0)) | set_vec;
    mask_d   = mask_we ? wdata_lo : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/rtc_shadow_timer.sv
`timescale 1ns/1ps
module rtc_shadow_timer
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned TICKS_PER_MS = 32,
  parameter int unsigned MS_PER_SEC   = 1000,
  parameter int unsigned COPY_PERIOD  = 8,
  parameter int unsigned BUSY_CYCLES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned MS_W = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;

  logic                      wr_secs, wr_mask, wr_stat, rd_msec;
  logic [MS_W-1:0]           ms_live, pub_ms;
  logic [31:0]               sec_live, sec_next, pub_sec;
  logic                      sec_step, busy_w;
  logic [N_ALARM-1:0][31:0]  alm_vals;
  logic [N_ALARM-1:0]        hit_w;
  logic [STAT_W-1:0]         stat_w, mask_w;
  word_t                     shadow_q, shadow_d, rdata_d;

  assign wr_secs = bus_wr && (bus_addr == ADDR_W'(REG_SECS));
  assign wr_mask = bus_wr && (bus_addr == ADDR_W'(REG_MASK));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
  assign rd_msec = bus_rd && (bus_addr == ADDR_W'(REG_MSEC));

  rtc_time_core #(
    .TICKS_PER_MS(TICKS_PER_MS), .MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .sec_load(wr_secs), .sec_wdata(bus_wdata),
    .ms_q(ms_live), .sec_q(sec_live), .sec_step(sec_step), .sec_next(sec_next)
  );

  rtc_publish #(
    .COPY_PERIOD(COPY_PERIOD), .BUSY_CYCLES(BUSY_CYCLES), .MS_W(MS_W)
  ) u_pub (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .live_sec(sec_live), .live_ms(ms_live),
    .pub_sec(pub_sec), .pub_ms(pub_ms), .busy(busy_w)
  );

  // Alarm value registers, one per compare channel
  generate
    for (genvar i = 0; i < N_ALARM; i++) begin : g_alm
      logic        we;
      logic [31:0] val_q, val_d;
      assign we = bus_wr && (bus_addr == ADDR_W'(REG_ALM0 + 4 * i));
      always_comb val_d = we ? bus_wdata : val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
      end
      assign alm_vals[i] = val_q;
    end
  endgenerate

  rtc_alarm_irq #(.N_ALARM(N_ALARM), .STAT_W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .sec_step(sec_step), .sec_next(sec_next),
    .alarm_val(alm_vals), .clr_we(wr_stat), .mask_we(wr_mask),
    .wdata_lo(bus_wdata[STAT_W-1:0]),
    .status_q(stat_w), .mask_q(mask_w), .hit(hit_w), .irq(irq)
  );

  // Shadow seconds follow the published seconds on a milliseconds read
  always_comb shadow_d = rd_msec ? pub_sec : shadow_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  always_comb begin
    rdata_d = '0;
    case (bus_addr)
      ADDR_W'(REG_BUSY):   rdata_d = {31'b0, busy_w};
      ADDR_W'(REG_SECS):   rdata_d = pub_sec;
      ADDR_W'(REG_SHADOW): rdata_d = shadow_q;
      ADDR_W'(REG_MSEC):   rdata_d = {{(32 - MS_W){1'b0}}, pub_ms};
      ADDR_W'(REG_MASK):   rdata_d = {{(32 - STAT_W){1'b0}}, mask_w};
      ADDR_W'(REG_STAT):   rdata_d = {{(32 - STAT_W){1'b0}}, stat_w};
      default:             rdata_d = '0;
    endcase
    for (int i = 0; i < N_ALARM; i++) begin
      if (bus_addr == ADDR_W'(REG_ALM0 + 4 * i)) rdata_d = alm_vals[i];
    end
  end
  assign bus_rdata = rdata_d;
endmodule

// File: rtl/rtc_shadow_timer_chk.sv
`timescale 1ns/1ps
module rtc_shadow_timer_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned MS_W       = 10,
  parameter int unsigned MS_PER_SEC = 1000,
  parameter int unsigned STAT_W     = 5,
  parameter int unsigned N_ALARM    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     slow_tick,
  input logic                     bus_rd,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [N_ALARM-1:0]       clr_bits,
  input logic                     busy,
  input logic [MS_W-1:0]          ms_live,
  input logic [STAT_W-1:0]        status_q,
  input logic [STAT_W-1:0]        mask_q,
  input logic [N_ALARM-1:0]       hit,
  input logic [N_ALARM-1:0][31:0] alm_vals,
  input logic [31:0]              shadow_q,
  input logic                     irq
);
  import rtc_pkg::*;

  a_r3_busy_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(slow_tick));

  a_r2_ms_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ms_live) < int'(MS_PER_SEC));

  a_r4_shadow_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == ADDR_W'(REG_MSEC)) |=> $stable(shadow_q));

  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[STAT_W-1:N_ALARM] == '0);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  generate
    for (genvar i = 0; i < N_ALARM; i++) begin : g_a
      a_r6_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |=> status_q[i]);
      a_r7_zero_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_vals[i] == '0 && !status_q[i]) |=> !status_q[i]);
      a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_STAT) && clr_bits[i] && !hit[i]) |=> !status_q[i]);
    end
  endgenerate
endmodule

bind rtc_shadow_timer rtc_shadow_timer_chk #(
  .ADDR_W(ADDR_W), .MS_W(MS_W), .MS_PER_SEC(MS_PER_SEC),
  .STAT_W(rtc_pkg::STAT_W), .N_ALARM(rtc_pkg::N_ALARM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_addr(bus_addr),
  .clr_bits(bus_wdata[rtc_pkg::N_ALARM-1:0]),
  .busy(busy_w), .ms_live(ms_live), .status_q(stat_w), .mask_q(mask_w),
  .hit(hit_w), .alm_vals(alm_vals), .shadow_q(shadow_q), .irq(irq)
);

// File: tb/rtc_shadow_timer_bench.sv
`timescale 1ns/1ps
module rtc_shadow_timer_bench;
  localparam int unsigned TPM = 2;
  localparam int unsigned MPS = 5;
  localparam int unsigned CPP = 8;
  localparam int unsigned BSY = 3;
  localparam logic [7:0] A_BUSY = 8'h04, A_SECS = 8'h08, A_SHAD = 8'h0C,
                         A_MSEC = 8'h10, A_ALM0 = 8'h14, A_ALM1 = 8'h18,
                         A_MASK = 8'h28, A_STAT = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;

  // Reference model built from the requirements
  int unsigned m_pre = 0, m_ms = 0, m_cp = 0, m_pub_ms = 0;
  logic [31:0] m_sec = '0, m_pub_sec = '0, m_shadow = '0, m_alm0 = '0, m_alm1 = '0;
  logic [4:0]  m_stat = '0, m_mask = '0;

  rtc_shadow_timer #(
    .ADDR_W(8), .TICKS_PER_MS(TPM), .MS_PER_SEC(MPS),
    .COPY_PERIOD(CPP), .BUSY_CYCLES(BSY)
  ) u_rtc_shadow_timer (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // All tasks start at a falling edge and end at a falling edge
  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
    if (a == A_MSEC) m_shadow = m_pub_sec;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      A_SECS: m_sec = d;
      A_ALM0: m_alm0 = d;
      A_ALM1: m_alm1 = d;
      A_MASK: m_mask = d[4:0];
      A_STAT: m_stat = m_stat & ~d[4:0];
      default: ;
    endcase
  endtask

  task automatic tick();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    if (m_pre == TPM - 1) begin
      m_pre = 0;
      if (m_ms == MPS - 1) begin
        m_ms = 0;
        m_sec = m_sec + 32'd1;
        if (m_alm0 != 0 && m_sec == m_alm0) m_stat[0] = 1'b1;
        if (m_alm1 != 0 && m_sec == m_alm1) m_stat[1] = 1'b1;
      end else m_ms++;
    end else m_pre++;
    if (m_cp == CPP - 1) begin
      m_cp = 0;
      m_pub_sec = m_sec;
      m_pub_ms  = m_ms;
    end else m_cp++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic check_time(input string tag);
    logic [31:0] d;
    bus_read(A_SECS, d); check({tag, " seconds"}, d, m_pub_sec);
    bus_read(A_MSEC, d); check({tag, " millis"}, d, m_pub_ms);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_read(A_BUSY, d); check("R1 busy", d, 0);
    bus_read(A_SECS, d); check("R1 seconds", d, 0);
    bus_read(A_SHAD, d); check("R1 shadow", d, 0);
    bus_read(A_ALM0, d); check("R1 alarm A", d, 0);
    bus_read(A_ALM1, d); check("R1 alarm B", d, 0);
    bus_read(A_MASK, d); check("R1 mask", d, 0);
    bus_read(A_STAT, d); check("R1 status", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    run(3);
    bus_read(A_MSEC, d); check("R3 no copy before period", d, 0);
    run(5);
    check_time("R2 first publish");
    for (int k = 0; k < 4; k++) begin
      run(CPP);
      check_time("R2 later publish");
    end
  endtask

  task automatic t_busy_write();
    logic [31:0] d, old;
    while (m_cp != CPP - 1) run(1);
    old = m_pub_sec;
    tick();
    old = m_pub_sec;
    bus_read(A_BUSY, d); check("R3 busy high in window", d, 1);
    @(negedge clk);
    bus_write(A_SECS, 32'h0000_ABCD);
    bus_read(A_SECS, d); check("R5 write not yet published", d, old);
    bus_read(A_BUSY, d); check("R3 busy low after window", d, 0);
    run(CPP);
    check_time("R5 write in next publish");
  endtask

  task automatic t_shadow();
    logic [31:0] d, held;
    bus_read(A_MSEC, d);
    held = m_shadow;
    run(CPP);
    bus_read(A_SHAD, d); check("R4 shadow held", d, held);
    bus_read(A_MSEC, d);
    bus_read(A_SHAD, d); check("R4 shadow reload", d, m_pub_sec);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    bus_write(A_ALM0, m_sec + 32'd1);
    run(TPM * MPS);
    bus_read(A_STAT, d); check("R6 alarm A pending", d, {27'b0, m_stat});
    check("R9 irq masked", {31'b0, irq}, 0);
    bus_write(A_MASK, 32'h1);
    check("R9 irq on", {31'b0, irq}, 1);
    bus_write(A_STAT, 32'h2);
    bus_read(A_STAT, d); check("R8 other bit kept", d, {27'b0, m_stat});
    bus_write(A_STAT, 32'h1);
    bus_read(A_STAT, d); check("R8 bit cleared", d, 0);
    check("R9 irq off", {31'b0, irq}, 0);
    bus_write(A_ALM1, m_sec + 32'd1);
    bus_write(A_MASK, 32'h2);
    run(TPM * MPS);
    bus_read(A_STAT, d); check("R6 alarm B pending", d, {27'b0, m_stat});
    check("R9 irq alarm B", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, d); check("R8 clear all", d, 0);
  endtask

  task automatic t_zero_wrap();
    logic [31:0] d;
    bus_write(A_ALM0, 32'h0);
    bus_write(A_ALM1, 32'h0);
    bus_write(A_MASK, 32'h1F);
    bus_write(A_SECS, 32'hFFFF_FFFF);
    run(TPM * MPS);
    bus_read(A_STAT, d); check("R7 zero alarm silent", d, 0);
    check("R7 irq silent", {31'b0, irq}, 0);
    while (m_cp != 0) run(1);
    check_time("R2 seconds wrap");
    check("R2 wrapped value small", {31'b0, (m_pub_sec < 32'd2)}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_busy_write();
    t_shadow();
    t_alarm();
    t_zero_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule